// File: doc/BRIEF.md
# Interrupt IN Endpoint Handshake Controller

This block runs the transmit side of a device interrupt IN endpoint. It holds the flag that firmware raises once a packet sits in the endpoint FIFO. It answers each IN token with either a data packet or a NAK. It then waits for the host handshake, and it decides what happens to the FIFO, the flag and the DATA0/DATA1 toggle. The packet engine does the serialization and signals when the packet has left. A per-bit-time strobe drives a handshake timeout whose limit is set by an input.

A mode input selects one of two behaviours. In toggle mode the endpoint acts like a bulk IN endpoint: a packet that gets no handshake stays in place and goes out again with the same PID on the next token. In non-toggle mode every packet that was sent counts as finished. A missing handshake still empties the FIFO and advances the toggle, and a two-bit status output reports the error. The transaction format is the same in both modes.

Top module: `intin_hs_ctrl`

## Requirements
- R1: After reset, status is IDLE (0), data_pid is DATA0 (0), data_set is 0, and send_data, send_nak and fifo_clr are all 0.
- R2: A one-cycle fw_set pulse makes data_set read 1 from the next cycle.
- R3: An IN token that arrives while the endpoint is not busy and data_set is 0 produces a one-cycle send_nak in the next cycle. status, data_pid and data_set keep their values, and send_data stays 0.
- R4: An IN token that arrives while the endpoint is not busy and data_set is 1 produces a one-cycle send_data in the next cycle, with data_pid giving the PID (0=DATA0, 1=DATA1). status reads BUSY (1) from that cycle until the handshake resolves, and data_pid holds steady throughout.
- R5: After pkt_done, an ack_rx ends the transaction at the next edge. In that cycle fifo_clr pulses for one cycle, data_set reads 0, data_pid has flipped, and status reads READY (2).
- R6: With toggle_mode=0, a handshake timeout does the same as an ack, except that status reads TX_ERR (3).
- R7: With toggle_mode=1, a handshake timeout sets status to IDLE. There is no fifo_clr, data_set stays 1 and data_pid is unchanged, so the next token resends with the same PID.
- R8: The timeout counter starts from zero at pkt_done and counts bit_stb pulses. After timeout_lim pulses the transaction resolves at the next clock edge. An ack_rx that arrives at that same edge or earlier takes precedence and cancels the timeout.
- R9: A bus_reset or ep_cfg pulse returns data_pid to DATA0 at the next edge.
- R10: ack_rx and pkt_done have no effect outside the phase in which they are expected.
- R11: An IN token that arrives while status is BUSY produces neither send_data nor send_nak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| toggle_mode | input | 1 | 1 = bulk-like retry, 0 = drop on missing handshake |
| timeout_lim | input | TW | Handshake timeout in bit times |
| bit_stb | input | 1 | One pulse per bit time |
| fw_set | input | 1 | Firmware marks the FIFO as loaded |
| tok_in | input | 1 | IN token addressed to this endpoint |
| pkt_done | input | 1 | Packet engine finished sending data |
| ack_rx | input | 1 | Host ACK handshake received |
| bus_reset | input | 1 | Bus reset seen |
| ep_cfg | input | 1 | Endpoint configure strobe |
| send_data | output | 1 | Command packet engine to send data |
| send_nak | output | 1 | Command packet engine to send NAK |
| data_pid | output | 1 | Current data toggle (0=DATA0, 1=DATA1) |
| fifo_clr | output | 1 | One-cycle FIFO clear strobe |
| data_set | output | 1 | FIFO loaded flag |
| status | output | 2 | IDLE=0, BUSY=1, READY=2, TX_ERR=3 |

## Verification
A wrong phase shows up at the ports within one token. A stuck busy phase turns the next token's reply into silence instead of a data packet or NAK. A phase that leaves too early gives the wrong status on the very next cycle. A toggle that flips at the wrong time is visible in data_pid on the next send_data or fifo_clr. A miscounted timeout moves the resolving edge relative to the bit_stb count, so the bench samples status in the cycle just before the expected expiry and again just after it.

// File: rtl/intin_pkg.sv
package intin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_READY = 2'd2,
        ST_TXERR = 2'd3
    } ep_status_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_WAIT = 2'd2
    } txn_phase_e;

    typedef struct packed {
        logic       advance;   // free FIFO, clear flag, flip toggle
        ep_status_e status;
    } outcome_t;

    // Decide what a resolved handshake does to the endpoint.
    function automatic outcome_t resolve(input logic acked, input logic tog_mode);
        outcome_t oc;
        if (acked) begin
            oc.advance = 1'b1;
            oc.status  = ST_READY;
        end else if (tog_mode) begin
            oc.advance = 1'b0;
            oc.status  = ST_IDLE;
        end else begin
            oc.advance = 1'b1;
            oc.status  = ST_TXERR;
        end
        return oc;
    endfunction

endpackage

// File: rtl/intin_hs_timer.sv
module intin_hs_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          bit_stb,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (bit_stb && (cnt != limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == limit);
endmodule

// File: rtl/intin_toggle.sv
module intin_toggle (
    input  logic clk,
    input  logic rst,
    input  logic zero,
    input  logic flip,
    output logic pid
);
    always_ff @(posedge clk) begin
        if (rst || zero) begin
            pid <= 1'b0;
        end else if (flip) begin
            pid <= ~pid;
        end
    end
endmodule

// File: rtl/intin_txn_fsm.sv
module intin_txn_fsm
    import intin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       toggle_mode,
    input  logic       fw_set,
    input  logic       tok_in,
    input  logic       pkt_done,
    input  logic       ack_rx,
    input  logic       expired,
    output logic       timer_run,
    output logic       flip,
    output logic       send_data,
    output logic       send_nak,
    output logic       fifo_clr,
    output logic       data_set,
    output ep_status_e status
);
    txn_phase_e phase;
    outcome_t   oc;
    logic       resolve_now;

    assign resolve_now = (phase == PH_WAIT) && (ack_rx || expired);
    assign oc          = resolve(ack_rx, toggle_mode);
    assign flip        = resolve_now && oc.advance;
    assign timer_run   = (phase == PH_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            status    <= ST_IDLE;
            data_set  <= 1'b0;
            send_data <= 1'b0;
            send_nak  <= 1'b0;
            fifo_clr  <= 1'b0;
        end else begin
            send_data <= 1'b0;
            send_nak  <= 1'b0;
            fifo_clr  <= 1'b0;
            if (fw_set) begin
                data_set <= 1'b1;
            end
            case (phase)
                PH_IDLE: begin
                    if (tok_in) begin
                        if (data_set) begin
                            send_data <= 1'b1;
                            status    <= ST_BUSY;
                            phase     <= PH_SEND;
                        end else begin
                            send_nak <= 1'b1;
                        end
                    end
                end
                PH_SEND: begin
                    if (pkt_done) begin
                        phase <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (resolve_now) begin
                        phase  <= PH_IDLE;
                        status <= oc.status;
                        if (oc.advance) begin
                            fifo_clr <= 1'b1;
                            data_set <= 1'b0;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/intin_hs_ctrl.sv
module intin_hs_ctrl
    import intin_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          toggle_mode,
    input  logic [TW-1:0] timeout_lim,
    input  logic          bit_stb,
    input  logic          fw_set,
    input  logic          tok_in,
    input  logic          pkt_done,
    input  logic          ack_rx,
    input  logic          bus_reset,
    input  logic          ep_cfg,
    output logic          send_data,
    output logic          send_nak,
    output logic          data_pid,
    output logic          fifo_clr,
    output logic          data_set,
    output logic [1:0]    status
);
    logic       timer_run;
    logic       expired;
    logic       flip;
    ep_status_e st;

    intin_hs_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (timer_run),
        .bit_stb (bit_stb),
        .limit   (timeout_lim),
        .expired (expired)
    );

    intin_toggle u_tog (
        .clk  (clk),
        .rst  (rst),
        .zero (bus_reset || ep_cfg),
        .flip (flip),
        .pid  (data_pid)
    );

    intin_txn_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .toggle_mode (toggle_mode),
        .fw_set      (fw_set),
        .tok_in      (tok_in),
        .pkt_done    (pkt_done),
        .ack_rx      (ack_rx),
        .expired     (expired),
        .timer_run   (timer_run),
        .flip        (flip),
        .send_data   (send_data),
        .send_nak    (send_nak),
        .fifo_clr    (fifo_clr),
        .data_set    (data_set),
        .status      (st)
    );

    assign status = st;
endmodule

// File: rtl/intin_hs_chk.sv
module intin_hs_chk (
    input logic       clk,
    input logic       rst,
    input logic       tok_in,
    input logic       bus_reset,
    input logic       ep_cfg,
    input logic       toggle_mode,
    input logic       send_data,
    input logic       send_nak,
    input logic       fifo_clr,
    input logic       data_pid,
    input logic       data_set,
    input logic [1:0] status
);
    AST_NAK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (tok_in && !data_set && status != 2'd1) |=> (send_nak && !send_data)); // R3

    AST_DATA_WHEN_SET: assert property (@(posedge clk) disable iff (rst)
        (tok_in && data_set && status != 2'd1) |=> (send_data && status == 2'd1)); // R4

    AST_NO_REPLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (tok_in && status == 2'd1 && !send_data) |=> (!send_data && !send_nak)); // R11

    AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |-> (!data_set && (status == 2'd2 || status == 2'd3))); // R5

    AST_PID_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_reset || ep_cfg) |=> (data_pid == 1'b0)); // R9

    AST_PID_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd1 && !bus_reset && !ep_cfg) |=> (status != 2'd1 || $stable(data_pid))); // R4

    AST_RETRY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (toggle_mode && status == 2'd1) |=> (status != 2'd0 || (data_set && !fifo_clr))); // R7
endmodule

bind intin_hs_ctrl intin_hs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tok_in      (tok_in),
    .bus_reset   (bus_reset),
    .ep_cfg      (ep_cfg),
    .toggle_mode (toggle_mode),
    .send_data   (send_data),
    .send_nak    (send_nak),
    .fifo_clr    (fifo_clr),
    .data_pid    (data_pid),
    .data_set    (data_set),
    .status      (status)
);

// File: tb/tb_intin_hs_ctrl.sv
module tb_intin_hs_ctrl;
    localparam int TW  = 8;
    localparam int LIM = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          toggle_mode = 1'b1;
    logic [TW-1:0] timeout_lim = TW'(LIM);
    logic          bit_stb = 1'b0, fw_set = 1'b0, tok_in = 1'b0;
    logic          pkt_done = 1'b0, ack_rx = 1'b0, bus_reset = 1'b0, ep_cfg = 1'b0;
    logic          send_data, send_nak, data_pid, fifo_clr, data_set;
    logic [1:0]    status;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic exp_pid = 1'b0;
    logic [2:0] expq[$];   // {kind[1:0], pid}: 1=data, 2=nak, 3=clear

    always #4 clk = ~clk;  // 125 MHz

    intin_hs_ctrl #(.TW(TW)) dut (
        .clk(clk), .rst(rst), .toggle_mode(toggle_mode), .timeout_lim(timeout_lim),
        .bit_stb(bit_stb), .fw_set(fw_set), .tok_in(tok_in), .pkt_done(pkt_done),
        .ack_rx(ack_rx), .bus_reset(bus_reset), .ep_cfg(ep_cfg),
        .send_data(send_data), .send_nak(send_nak), .data_pid(data_pid),
        .fifo_clr(fifo_clr), .data_set(data_set), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: every command/clear pulse pops the next expected item.
    always @(negedge clk) begin
        if (!rst && (send_data || send_nak || fifo_clr)) begin
            logic [2:0] got;
            got = {send_data ? 2'd1 : (send_nak ? 2'd2 : 2'd3), data_pid};
            if (expq.size() == 0) begin
                chk(1'b0, "R10/R11 unexpected event", int'(got), 0);
            end else begin
                logic [2:0] e;
                e = expq.pop_front();
                chk(got == e, "R3/R4/R5/R6 event", int'(got), int'(e));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_fw();
        fw_set = 1'b1; tick(); fw_set = 1'b0;
    endtask

    task automatic token(input bit expect_data, input bit expect_reply);
        if (expect_reply) expq.push_back(expect_data ? {2'd1, exp_pid} : {2'd2, exp_pid});
        tok_in = 1'b1; tick(); tok_in = 1'b0;
    endtask

    task automatic done_pkt();
        pkt_done = 1'b1; tick(); pkt_done = 1'b0;
    endtask

    task automatic ack_expect_clear();
        exp_pid = ~exp_pid;
        expq.push_back({2'd3, exp_pid});
        ack_rx = 1'b1; tick(); ack_rx = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            bit_stb = 1'b1; tick();
        end
        bit_stb = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(status == 2'd0, "R1 status", status, 0);
        chk(data_pid == 1'b0, "R1 pid", data_pid, 0);
        chk(data_set == 1'b0, "R1 data_set", data_set, 0);
        chk(!send_data && !send_nak && !fifo_clr, "R1 pulses", send_data, 0);

        // R3 token with nothing loaded -> NAK, no state change
        token(1'b0, 1'b1);
        chk(status == 2'd0, "R3 status", status, 0);
        chk(data_set == 1'b0, "R3 data_set", data_set, 0);
        chk(data_pid == 1'b0, "R3 pid", data_pid, 0);

        // R2 firmware sets flag
        pulse_fw();
        chk(data_set == 1'b1, "R2 data_set", data_set, 1);

        // R4 data reply, BUSY
        token(1'b1, 1'b1);
        chk(status == 2'd1, "R4 busy", status, 1);
        // R11 token while busy ignored
        token(1'b0, 1'b0);
        chk(status == 2'd1, "R11 still busy", status, 1);
        // R10 ack before packet done ignored
        ack_rx = 1'b1; tick(); ack_rx = 1'b0;
        chk(status == 2'd1 && data_set, "R10 early ack", status, 1);

        // R5 ack completes
        done_pkt();
        ack_expect_clear();
        chk(status == 2'd2, "R5 ready", status, 2);
        chk(data_set == 1'b0, "R5 data_set", data_set, 0);
        chk(data_pid == exp_pid, "R5 pid", data_pid, exp_pid);

        // R10 ack / pkt_done while idle ignored
        ack_rx = 1'b1; pkt_done = 1'b1; tick(); ack_rx = 1'b0; pkt_done = 1'b0;
        tick();
        chk(status == 2'd2, "R10 idle ack", status, 2);

        // R6 + R8: non-toggle timeout
        toggle_mode = 1'b0;
        pulse_fw();
        token(1'b1, 1'b1);
        done_pkt();
        strobes(LIM);
        chk(status == 2'd1, "R8 busy before expiry", status, 1);
        exp_pid = ~exp_pid;
        expq.push_back({2'd3, exp_pid});
        tick();
        chk(status == 2'd3, "R6 tx_err", status, 3);
        chk(data_set == 1'b0, "R6 data_set", data_set, 0);
        chk(data_pid == exp_pid, "R6 pid", data_pid, exp_pid);

        // R7: toggle-mode timeout keeps packet
        toggle_mode = 1'b1;
        pulse_fw();
        token(1'b1, 1'b1);
        done_pkt();
        strobes(LIM);
        chk(status == 2'd1, "R8 busy before expiry (toggle)", status, 1);
        tick();
        chk(status == 2'd0, "R7 idle", status, 0);
        chk(data_set == 1'b1, "R7 data_set kept", data_set, 1);
        chk(data_pid == exp_pid, "R7 pid kept", data_pid, exp_pid);
        token(1'b1, 1'b1);   // resend with same PID
        done_pkt();
        strobes(LIM);
        // R8 ack at the expiry edge wins
        ack_expect_clear();
        chk(status == 2'd2, "R8 ack wins", status, 2);
        chk(data_pid == exp_pid, "R8 pid", data_pid, exp_pid);

        // R9 configure and bus reset
        ep_cfg = 1'b1; tick(); ep_cfg = 1'b0;
        exp_pid = 1'b0;
        chk(data_pid == 1'b0, "R9 ep_cfg", data_pid, 0);
        pulse_fw();
        token(1'b1, 1'b1);
        done_pkt();
        ack_expect_clear();
        chk(data_pid == 1'b1, "R9 advanced", data_pid, 1);
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        exp_pid = 1'b0;
        chk(data_pid == 1'b0, "R9 bus_reset", data_pid, 0);

        tick();
        chk(expq.size() == 0, "R4/R5 pending events", expq.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule